// File: doc/BRIEF.md
# Coherent Position Counter with Byte-Wide Read Port

This block holds the position count of an incremental encoder. The decoder in front of it supplies a count-enable and a direction on every clock. A binary up/down counter follows those inputs, and a holding register copies the counter on each rising clock edge. A host reads the holding register one byte at a time over an 8-bit tri-state bus. A select input picks the high or the low byte, and an active-low enable drives the bus.

A wide count read one byte at a time can tear if the count moves between the two byte reads. To prevent this, a high-byte read freezes the holding register. The freeze is taken on the falling clock edge and lasts until the host ends its low-byte read. During that time the live counter keeps counting, so when the holding register resumes tracking, no counts have been lost.

Each time the counter wraps, the block sends a short cascade pulse and a direction flag, so that an external counter can extend the range.

Top module: `pos_latch_ctr`

## Requirements
- R1: The active-low asynchronous reset clears the counter, the holding register and the freeze state, and sets `cas_dir` to 0. While reset is held, a read returns 0.
- R2: On a rising edge with `cnt_en`=1 and `cnt_up`=1, the counter increases by one. With `cnt_en`=0 it keeps its value.
- R3: On a rising edge with `cnt_en`=1 and `cnt_up`=0, the counter decreases by one.
- R4: Counting up from the all-ones value gives 0, and counting down from 0 gives the all-ones value.
- R5: While not frozen, the holding register takes, at each rising edge, the counter value from just before that edge.
- R6: With `oe_n`=0, the bus carries holding-register bits 15:8 when `sel_lo`=0, and bits 7:0 when `sel_lo`=1. Unused upper bits read as zero.
- R7: With `oe_n`=1, the block does not drive the bus.
- R8: A falling edge that finds `sel_lo`=0 and `oe_n`=0 freezes the holding register.
- R9: While the holding register is frozen, the counter keeps following `cnt_en` and `cnt_up`.
- R10: The freeze ends at a falling edge that finds `sel_lo`=1 and `oe_n`=1, provided the previous falling edge found `oe_n`=0. The holding register tracks the counter again from the next rising edge.
- R11: On a wrap, `cas_pulse` goes high from that rising edge until the next falling edge. `cas_dir` then shows the direction of that wrap (1 = up) and holds it until the next wrap.
- R12: A low-byte read (`sel_lo`=1, `oe_n`=0) does not freeze the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count pulse from the decoder |
| cnt_up | input | 1 | Count direction, 1 = up |
| sel_lo | input | 1 | Byte select: 0 = high byte, 1 = low byte |
| oe_n | input | 1 | Bus output enable, active low |
| data | inout | 8 | Tri-state byte bus |
| cas_pulse | output | 1 | Cascade count pulse on wrap |
| cas_dir | output | 1 | Direction of the last wrap, 1 = up |

## Verification
The counter is driven with sparse enable patterns upward, alternating patterns downward, and a full upward sweep through every count value to the wrap. A reference count is compared byte by byte on every cycle, so a wrong step, a wrong wrap or a holding register that lags by the wrong amount shows up on the bus.

Two-byte reads are placed at arbitrary counts and exactly on the wrap edge, with counting continued during the freeze. These reads separate a correct freeze from one that never engages, one that releases too early, and one that loses counts.

A high-byte read, a resume, and then a read with `oe_n` high while the bench drives a probe value are used to check that the freeze releases correctly and that the bus is not driven when disabled. A reset asserted mid-freeze checks that reset clears everything.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;
endpackage

// File: rtl/pcb_counter.sv
module pcb_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         cnt_up,
    output logic [W-1:0] cnt_o,
    output logic         cas_tog_o,
    output logic         cas_dir_o
);
    import pcb_pkg::*;

    localparam logic [W-1:0] TOP = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         tog;   // flips once per wrap
        dir_e         dir;
    } ctr_t;

    ctr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cnt_en) begin
            if (cnt_up) begin
                if (s_q.cnt == TOP) begin
                    s_d.tog = ~s_q.tog;
                    s_d.dir = DIR_UP;
                end
                s_d.cnt = s_q.cnt + 1'b1;
            end else begin
                if (s_q.cnt == '0) begin
                    s_d.tog = ~s_q.tog;
                    s_d.dir = DIR_DOWN;
                end
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cnt: '0, tog: 1'b0, dir: DIR_DOWN};
        else        s_q <= s_d;
    end

    assign cnt_o     = s_q.cnt;
    assign cas_tog_o = s_q.tog;
    assign cas_dir_o = (s_q.dir == DIR_UP);

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && cnt_up && s_q.cnt != TOP) |=> s_q.cnt == $past(s_q.cnt) + 1'b1); // R2
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(s_q.cnt)); // R2
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_up && s_q.cnt != '0) |=> s_q.cnt == $past(s_q.cnt) - 1'b1); // R3
    AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && cnt_up && s_q.cnt == TOP) |=> s_q.cnt == '0); // R4
    AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_up && s_q.cnt == '0) |=> s_q.cnt == TOP); // R4
    AST_CAS_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && cnt_up && s_q.cnt == TOP) |=> s_q.tog != $past(s_q.tog)); // R11
endmodule

// File: rtl/pcb_fall_stage.sv
module pcb_fall_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_lo,
    input  logic oe_n,
    input  logic cas_tog_i,
    output logic inh_o,
    output logic cas_seen_o
);
    typedef struct packed {
        logic inh;
        logic oe_prev;
        logic seen;
    } fall_t;

    fall_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.oe_prev = oe_n;
        s_d.seen    = cas_tog_i;
        if (!sel_lo && !oe_n)
            s_d.inh = 1'b1;
        else if (s_q.inh && sel_lo && oe_n && !s_q.oe_prev)
            s_d.inh = 1'b0;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{inh: 1'b0, oe_prev: 1'b1, seen: 1'b0};
        else        s_q <= s_d;
    end

    assign inh_o      = s_q.inh;
    assign cas_seen_o = s_q.seen;

    AST_INH_SET: assert property (@(negedge clk) disable iff (!rst_n)
        (!sel_lo && !oe_n) |=> s_q.inh); // R8
    AST_LOW_READ_NO_SET: assert property (@(negedge clk) disable iff (!rst_n)
        (!s_q.inh && sel_lo) |=> !s_q.inh); // R12
    AST_INH_KEEP: assert property (@(negedge clk) disable iff (!rst_n)
        (s_q.inh && !(sel_lo && oe_n)) |=> s_q.inh); // R10
endmodule

// File: rtl/pcb_latch.sv
module pcb_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inh_i,
    input  logic [W-1:0] cnt_i,
    output logic [W-1:0] lat_o
);
    logic [W-1:0] lat_d, lat_q;

    always_comb begin
        lat_d = inh_i ? lat_q : cnt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign lat_o = lat_q;

    AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        inh_i |=> $stable(lat_q)); // R8
    AST_LATCH_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        !inh_i |=> lat_q == $past(cnt_i)); // R5
endmodule

// File: rtl/pos_latch_ctr.sv
module pos_latch_ctr #(
    parameter int W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_en,
    input  logic       cnt_up,
    input  logic       sel_lo,
    input  logic       oe_n,
    inout  wire  [7:0] data,
    output logic       cas_pulse,
    output logic       cas_dir
);
    localparam int BUS_W = 16;

    logic [W-1:0]     cnt, lat;
    logic             tog, seen, inh;
    logic [BUS_W-1:0] lat_wide;
    logic [7:0]       rd_byte;

    pcb_counter #(.W(W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_up(cnt_up),
        .cnt_o(cnt), .cas_tog_o(tog), .cas_dir_o(cas_dir)
    );

    pcb_fall_stage u_fall (
        .clk(clk), .rst_n(rst_n), .sel_lo(sel_lo), .oe_n(oe_n),
        .cas_tog_i(tog), .inh_o(inh), .cas_seen_o(seen)
    );

    pcb_latch #(.W(W)) u_lat (
        .clk(clk), .rst_n(rst_n), .inh_i(inh), .cnt_i(cnt), .lat_o(lat)
    );

    assign lat_wide  = BUS_W'(lat);
    assign rd_byte   = sel_lo ? lat_wide[7:0] : lat_wide[15:8];
    assign data      = oe_n ? 8'bzzzz_zzzz : rd_byte;
    assign cas_pulse = tog ^ seen;

    initial begin
        AST_WIDTH_RANGE: assert (W >= 9 && W <= 16); // R6
    end
endmodule

// File: tb/pos_latch_ctr_test.sv
module pos_latch_ctr_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, cnt_en, cnt_up, sel_lo, oe_n, probe_en;
    wire  [7:0] data;
    logic cas_pulse, cas_dir;

    int checks = 0;
    int fails  = 0;

    logic [15:0] m_cnt, m_lat;
    logic        m_inh, m_prev, m_dir;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign data = probe_en ? 8'hA5 : 8'bzzzz_zzzz;

    pos_latch_ctr #(.W(16)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_up(cnt_up),
        .sel_lo(sel_lo), .oe_n(oe_n), .data(data),
        .cas_pulse(cas_pulse), .cas_dir(cas_dir)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: inputs held from just after a falling edge to just after the next one.
    task automatic cyc(input logic en, input logic up, input logic s, input logic o);
        logic wrapped;
        cnt_en = en; cnt_up = up; sel_lo = s; oe_n = o; probe_en = o;
        @(posedge clk); #1;
        wrapped = 1'b0;
        if (!rst_n) begin
            m_cnt = '0; m_lat = '0; m_inh = 1'b0; m_prev = 1'b1; m_dir = 1'b0;
        end else begin
            if (!m_inh) m_lat = m_cnt;            // R5 lag by one edge
            if (en) begin
                if (up && m_cnt == 16'hFFFF)  begin wrapped = 1'b1; m_dir = 1'b1; end
                if (!up && m_cnt == 16'h0000) begin wrapped = 1'b1; m_dir = 1'b0; end
                m_cnt = up ? m_cnt + 16'd1 : m_cnt - 16'd1;   // R2 R3 R4 R9
            end
        end
        chk(cas_pulse === wrapped, "R11 pulse after rise", 16'(cas_pulse), 16'(wrapped));
        chk(cas_dir === m_dir, "R11 direction", 16'(cas_dir), 16'(m_dir));
        @(negedge clk); #1;
        if (rst_n) begin
            if (!s && !o) m_inh = 1'b1;                          // R8
            else if (m_inh && s && o && !m_prev) m_inh = 1'b0;   // R10
            m_prev = o;
        end
        chk(cas_pulse === 1'b0, "R11 pulse low after fall", 16'(cas_pulse), 16'h0);
        if (o) chk(data === 8'hA5, "R7 bus released", 16'(data), 16'h00A5);
        else   chk(data === (s ? m_lat[7:0] : m_lat[15:8]), s ? "R5 R6 low byte" : "R6 high byte",
                   16'(data), 16'(s ? m_lat[7:0] : m_lat[15:8]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] frozen;
        rst_n = 1'b0; cnt_en = 0; cnt_up = 0; sel_lo = 1; oe_n = 1; probe_en = 1;
        m_cnt = '0; m_lat = '0; m_inh = 0; m_prev = 1; m_dir = 0;
        repeat (2) cyc(1, 1, 1, 1);
        cyc(1, 1, 1, 0);
        chk(data === 8'h00, "R1 reset low byte", 16'(data), 16'h0);
        cyc(1, 1, 0, 0);
        chk(data === 8'h00, "R1 reset high byte", 16'(data), 16'h0);
        chk(cas_dir === 1'b0, "R1 reset direction", 16'(cas_dir), 16'h0);
        cyc(0, 0, 1, 1);
        rst_n = 1'b1;

        // Sparse upward counting with continuous low-byte reads (R2, R12)
        for (int i = 0; i < 300; i++) cyc(i % 3 != 0, 1, 1, 0);
        chk(data === m_cnt[7:0] - 8'd1 || data === m_cnt[7:0], "R12 low read keeps tracking",
            16'(data), 16'(m_lat[7:0]));
        // Alternating downward counting (R3)
        for (int i = 0; i < 100; i++) cyc(i % 2 == 1, 0, 1, 0);

        // Coherent two-byte read while counting continues (R8, R9, R10)
        cyc(1, 1, 0, 0);
        frozen = m_lat;
        for (int i = 0; i < 4; i++) begin
            cyc(1, 1, 1, 0);
            chk(data === frozen[7:0], "R8 low byte frozen", 16'(data), 16'(frozen[7:0]));
        end
        cyc(0, 0, 1, 1);              // end of low-byte read clears the freeze
        cyc(0, 0, 1, 0);              // first edge after clear: latch resumes
        chk(data === m_cnt[7:0], "R9 counts kept during freeze", 16'(data), 16'(m_cnt[7:0]));
        cyc(0, 0, 0, 0);
        chk(data === m_cnt[15:8], "R10 resumed high byte", 16'(data), 16'(m_cnt[15:8]));
        cyc(0, 0, 1, 0);
        cyc(0, 0, 1, 1);

        // Full upward sweep to the wrap, read taken on the wrap edge (R4, R11)
        while (m_cnt != 16'hFFFF) cyc(1, 1, 1, 0);
        cyc(1, 1, 0, 0);
        chk(data === 8'hFF, "R4 high byte before wrap", 16'(data), 16'h00FF);
        chk(m_cnt === 16'h0000, "R4 wrapped to zero", m_cnt, 16'h0);
        cyc(1, 1, 1, 0);
        chk(data === 8'hFF, "R8 low byte coherent at wrap", 16'(data), 16'h00FF);
        cyc(0, 0, 1, 1);
        for (int i = 0; i < 6; i++) cyc(1, 0, 1, 0);   // down through zero
        chk(cas_dir === 1'b0, "R11 direction after down wrap", 16'(cas_dir), 16'h0);
        cyc(0, 0, 0, 0);
        chk(data === 8'hFF, "R4 down wrap high byte", 16'(data), 16'h00FF);
        cyc(0, 0, 1, 0);
        cyc(0, 0, 1, 1);

        // Reset during a freeze (R1)
        cyc(1, 1, 0, 0);
        rst_n = 1'b0;
        cyc(1, 1, 0, 0);
        chk(data === 8'h00, "R1 reset clears frozen latch", 16'(data), 16'h0);
        cyc(0, 0, 1, 1);
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) cyc(1, 1, 1, 0);
        chk(data === 8'h04, "R1 R2 count from zero after reset", 16'(data), 16'h0004);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule